// File: doc/BRIEF.md
# Flash Program Pause/Resume Controller

This block is the command decoder and sequencing logic of a flash array. It allows a byte program that is already running to be put on hold, so that other locations can be read from the array, and later to be continued from where it stopped. Bus writes carry an 8-bit command code together with an address. A small engine model stands in for the analog program algorithm. It finishes a program after `PROG_CYCLES` clocks of progress and, once asked to pause, stops at its safe point `SUSP_LAT` clocks later. The storage is a behavioural memory whose reset contents are computed from the address: word `a` holds `(a*29+7)` truncated to `DATA_W` bits.

Reads are combinational on `busAddr`. The `readArray` output selects what `rdData` returns: the array word when it is high, the status byte when it is low. In the status byte, bit 7 means ready and bit 2 means program paused; every other bit reads 0. The command codes are 0x40 for program setup (the next bus write supplies the data and address), 0xB0 for pause, 0xD0 for continue, 0xFF for array reads and 0x70 for status reads.

Top module: `flash_pause_ctrl`

## Requirements
- R1: After reset the status byte is 0x80, `rdyBusy` is 1, `readArray` is 1, `pauseReq` is 0, and array reads return the computed initial contents.
- R2: A 0x40 write followed by a data write starts a program. On the capturing edge the status becomes 0x00, `rdyBusy` becomes 0 and `readArray` becomes 0. Exactly `PROG_CYCLES` clocks later, if the program was not paused, the status is 0x80 and the word holds the new data.
- R3: A 0xB0 write captured during a running program raises `pauseReq` on that edge. `rdyBusy` stays 0 until exactly `SUSP_LAT` clocks after the capturing edge.
- R4: In the paused state the status byte is 0x84 (bits 7 and 2 set) and `rdyBusy` is 1.
- R5: After a pause command, reads return the status byte until a 0xFF command is given. Whenever `rdyBusy` is 0, `readArray` is 0.
- R6: A 0xFF write while paused sets `readArray`, and reads of other addresses return their array contents.
- R7: While paused, a read of the address being programmed returns its old contents.
- R8: While paused, any write other than 0xFF, 0x70 or 0xD0 is ignored: the status byte, `readArray` and `pauseReq` are left unchanged.
- R9: A 0xD0 write while paused clears status bits 7 and 2, drives `rdyBusy` to 0, clears `readArray` and `pauseReq` on the capturing edge. The program then completes and writes its data.
- R10: A 0xB0 write when no program is running changes nothing: `pauseReq` stays 0, and the status byte and `readArray` are unchanged.
- R11: If the program completes before the pause safe point is reached, completion takes priority. The status returns to 0x80, bit 2 is never set, and `pauseReq` drops.
- R12: A 0x70 write while paused clears `readArray` and the block stays paused with status 0x84.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWe | input | 1 | Bus write strobe, sampled on the rising edge |
| busAddr | input | ADDR_W | Bus address for writes and reads |
| busWdata | input | DATA_W | Command code or program data |
| rdData | output | DATA_W | Read data: array word or status byte |
| statusOut | output | 8 | Status byte (bit 7 ready, bit 2 paused) |
| rdyBusy | output | 1 | 1 when ready, 0 when busy |
| readArray | output | 1 | 1 when reads return the array |
| pauseReq | output | 1 | Pause request to the program engine |

## Verification
The bench counts the clocks between the pause command and the paused state. A design that paused at once, or one cycle late, would break that count. It reads the address being programmed while paused, which catches a design that writes the new data early. It sends an unrelated command while paused, which exposes a design that leaves the paused state or changes the read mode. It also issues a pause just before the program finishes, to check that completion wins, and a pause while idle, which must leave `pauseReq` low and the status byte untouched.

// File: rtl/fpc_pkg.sv
package fpc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_BUSY,
    ST_PEND,
    ST_SUSP
  } ctlState_e;

  localparam logic [7:0] CMD_SETUP   = 8'h40;
  localparam logic [7:0] CMD_SUSPEND = 8'hB0;
  localparam logic [7:0] CMD_RESUME  = 8'hD0;
  localparam logic [7:0] CMD_RDARRAY = 8'hFF;
  localparam logic [7:0] CMD_RDSTAT  = 8'h70;

  localparam int STAT_READY_BIT = 7;
  localparam int STAT_SUSP_BIT  = 2;

  // strobes from control to datapath
  typedef struct packed {
    logic startProg;
    logic setReady;
    logic clrReady;
    logic setSusp;
    logic clrSusp;
    logic selArray;
    logic selStatus;
  } dpStrobe_t;

endpackage

// File: rtl/fpc_engine.sv
// Behavioural stand-in for the program algorithm: counts progress and
// reaches a pause safe point a fixed number of cycles after a request.
module fpc_engine #(
  parameter int PROG_CYCLES = 20,
  parameter int SUSP_LAT    = 4
) (
  input  logic clk,
  input  logic rstN,
  input  logic start,
  input  logic pauseReq,
  output logic engDone,
  output logic engAck
);

  localparam int PW = (PROG_CYCLES > 1) ? $clog2(PROG_CYCLES) : 1;
  localparam int LW = $clog2(SUSP_LAT + 1);
  localparam logic [PW-1:0] PROG_LAST = PW'(PROG_CYCLES - 1);
  localparam logic [LW-1:0] LAT_LAST  = LW'(SUSP_LAT - 1);

  logic          running;
  logic          paused;
  logic [PW-1:0] progCnt;
  logic [LW-1:0] latCnt;

  assign engDone = running && !paused && (progCnt == PROG_LAST);
  assign engAck  = running && pauseReq && !paused && !engDone && (latCnt == LAT_LAST);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      running <= 1'b0;
      paused  <= 1'b0;
      progCnt <= '0;
      latCnt  <= '0;
    end else if (start) begin
      running <= 1'b1;
      paused  <= 1'b0;
      progCnt <= '0;
      latCnt  <= '0;
    end else if (running) begin
      if (engDone) begin
        running <= 1'b0;
        latCnt  <= '0;
      end else begin
        if (!paused) progCnt <= progCnt + 1'b1;
        if (pauseReq && !paused) begin
          if (engAck) paused <= 1'b1;
          else        latCnt <= latCnt + 1'b1;
        end
        if (!pauseReq) begin
          paused <= 1'b0;
          latCnt <= '0;
        end
      end
    end
  end

endmodule

// File: rtl/fpc_control.sv
module fpc_control
  import fpc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       busWe,
  input  logic [7:0] cmdByte,
  input  logic       engDone,
  input  logic       engAck,
  output dpStrobe_t  strb,
  output logic       pauseReq
);

  ctlState_e state, stateNext;

  always_comb begin
    stateNext = state;
    strb      = '0;
    unique case (state)
      ST_IDLE: begin
        if (busWe) begin
          if (cmdByte == CMD_SETUP) begin
            stateNext      = ST_SETUP;
            strb.selStatus = 1'b1;
          end else if (cmdByte == CMD_RDARRAY) begin
            strb.selArray = 1'b1;
          end else if (cmdByte == CMD_RDSTAT) begin
            strb.selStatus = 1'b1;
          end
        end
      end
      ST_SETUP: begin
        if (busWe) begin
          stateNext      = ST_BUSY;
          strb.startProg = 1'b1;
          strb.clrReady  = 1'b1;
          strb.selStatus = 1'b1;
        end
      end
      ST_BUSY: begin
        if (engDone) begin
          stateNext     = ST_IDLE;
          strb.setReady = 1'b1;
        end else if (busWe && cmdByte == CMD_SUSPEND) begin
          stateNext      = ST_PEND;
          strb.selStatus = 1'b1;
        end
      end
      ST_PEND: begin
        if (engDone) begin
          stateNext     = ST_IDLE;
          strb.setReady = 1'b1;
        end else if (engAck) begin
          stateNext     = ST_SUSP;
          strb.setReady = 1'b1;
          strb.setSusp  = 1'b1;
        end
      end
      ST_SUSP: begin
        if (busWe) begin
          if (cmdByte == CMD_RDARRAY) begin
            strb.selArray = 1'b1;
          end else if (cmdByte == CMD_RDSTAT) begin
            strb.selStatus = 1'b1;
          end else if (cmdByte == CMD_RESUME) begin
            stateNext      = ST_BUSY;
            strb.clrReady  = 1'b1;
            strb.clrSusp   = 1'b1;
            strb.selStatus = 1'b1;
          end
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign pauseReq = (state == ST_PEND) || (state == ST_SUSP);

endmodule

// File: rtl/fpc_datapath.sv
module fpc_datapath
  import fpc_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strb,
  input  logic              engDone,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] rdData,
  output logic [7:0]        statusOut,
  output logic              readArray
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] memArr [DEPTH];
  logic [ADDR_W-1:0] progAddr;
  logic [DATA_W-1:0] progData;
  logic              statReady;
  logic              statSusp;

  // captured program target
  always_ff @(posedge clk) begin
    if (!rstN) begin
      progAddr <= '0;
      progData <= '0;
    end else if (strb.startProg) begin
      progAddr <= busAddr;
      progData <= busWdata;
    end
  end

  // array storage, only written at program completion
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) memArr[i] <= DATA_W'(i * 29 + 7);
    end else if (engDone) begin
      memArr[progAddr] <= progData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      statReady <= 1'b1;
      statSusp  <= 1'b0;
      readArray <= 1'b1;
    end else begin
      if (strb.setReady)      statReady <= 1'b1;
      else if (strb.clrReady) statReady <= 1'b0;
      if (strb.setSusp)       statSusp  <= 1'b1;
      else if (strb.clrSusp)  statSusp  <= 1'b0;
      if (strb.selArray)       readArray <= 1'b1;
      else if (strb.selStatus) readArray <= 1'b0;
    end
  end

  always_comb begin
    statusOut = '0;
    statusOut[STAT_READY_BIT] = statReady;
    statusOut[STAT_SUSP_BIT]  = statSusp;
  end

  assign rdData = readArray ? memArr[busAddr] : DATA_W'(statusOut);

endmodule

// File: rtl/flash_pause_ctrl.sv
module flash_pause_ctrl
  import fpc_pkg::*;
#(
  parameter int ADDR_W      = 4,
  parameter int DATA_W      = 8,
  parameter int PROG_CYCLES = 20,
  parameter int SUSP_LAT    = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] rdData,
  output logic [7:0]        statusOut,
  output logic              rdyBusy,
  output logic              readArray,
  output logic              pauseReq
);

  dpStrobe_t strb;
  logic      engDone;
  logic      engAck;

  fpc_control u_ctl (
    .clk      (clk),
    .rstN     (rstN),
    .busWe    (busWe),
    .cmdByte  (busWdata[7:0]),
    .engDone  (engDone),
    .engAck   (engAck),
    .strb     (strb),
    .pauseReq (pauseReq)
  );

  fpc_engine #(.PROG_CYCLES(PROG_CYCLES), .SUSP_LAT(SUSP_LAT)) u_eng (
    .clk      (clk),
    .rstN     (rstN),
    .start    (strb.startProg),
    .pauseReq (pauseReq),
    .engDone  (engDone),
    .engAck   (engAck)
  );

  fpc_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .engDone   (engDone),
    .busAddr   (busAddr),
    .busWdata  (busWdata),
    .rdData    (rdData),
    .statusOut (statusOut),
    .readArray (readArray)
  );

  assign rdyBusy = statusOut[STAT_READY_BIT];

endmodule

// File: rtl/fpc_checker.sv
module fpc_checker #(
  parameter int SUSP_LAT = 4
) (
  input logic       clk,
  input logic       rstN,
  input logic [7:0] statusOut,
  input logic       rdyBusy,
  input logic       readArray,
  input logic       pauseReq
);

  localparam int CW = $clog2(SUSP_LAT + 2);
  logic [CW-1:0] waitCnt;

  // cycles spent requesting a pause without reaching it
  always_ff @(posedge clk) begin
    if (!rstN || !pauseReq)    waitCnt <= '0;
    else if (!statusOut[2])    waitCnt <= waitCnt + 1'b1;
  end

  assert_pause_window_R3: assert property (@(posedge clk) disable iff (!rstN)
    waitCnt <= CW'(SUSP_LAT));

  assert_pause_after_req_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statusOut[2]) |-> pauseReq && $past(pauseReq));

  assert_paused_flags_R4: assert property (@(posedge clk) disable iff (!rstN)
    statusOut[2] |-> statusOut[7] && rdyBusy);

  assert_busy_reads_status_R5: assert property (@(posedge clk) disable iff (!rstN)
    !rdyBusy |-> !readArray);

  assert_paused_status_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    statusOut[2] && $past(statusOut[2]) |-> $stable(statusOut));

  assert_resume_busy_R9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(statusOut[2]) |-> !rdyBusy && !readArray && !pauseReq);

  assert_no_idle_pause_R10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pauseReq) |-> !rdyBusy);

endmodule

bind flash_pause_ctrl fpc_checker #(.SUSP_LAT(SUSP_LAT)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .statusOut (statusOut),
  .rdyBusy   (rdyBusy),
  .readArray (readArray),
  .pauseReq  (pauseReq)
);

// File: tb/flash_pause_ctrl_tb.sv
module flash_pause_ctrl_tb;

  localparam int ADDR_W      = 4;
  localparam int DATA_W      = 8;
  localparam int PROG_CYCLES = 20;
  localparam int SUSP_LAT    = 4;
  localparam int DEPTH       = 1 << ADDR_W;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              busWe = 1'b0;
  logic [ADDR_W-1:0] busAddr = '0;
  logic [DATA_W-1:0] busWdata = '0;
  logic [DATA_W-1:0] rdData;
  logic [7:0]        statusOut;
  logic              rdyBusy;
  logic              readArray;
  logic              pauseReq;

  int nCmp = 0;
  int nBad = 0;
  logic [DATA_W-1:0] expMem [DEPTH];

  always #5 clk = ~clk;

  flash_pause_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .PROG_CYCLES(PROG_CYCLES), .SUSP_LAT(SUSP_LAT)
  ) u_dut (
    .clk(clk), .rstN(rstN), .busWe(busWe), .busAddr(busAddr),
    .busWdata(busWdata), .rdData(rdData), .statusOut(statusOut),
    .rdyBusy(rdyBusy), .readArray(readArray), .pauseReq(pauseReq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nCmp++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  // drive one bus write at a negedge; returns at the negedge after capture
  task automatic busWrite(input logic [7:0] val, input logic [ADDR_W-1:0] a);
    busWe    = 1'b1;
    busWdata = val;
    busAddr  = a;
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic readAt(input logic [ADDR_W-1:0] a, output logic [DATA_W-1:0] d);
    busAddr = a;
    #1;
    d = rdData;
  endtask

  task automatic waitReady(input string req, input int limit);
    int n = 0;
    while (!rdyBusy && n < limit) begin
      @(negedge clk);
      n++;
    end
    chk(req, rdyBusy, 1);
  endtask

  task automatic startProgram(input logic [ADDR_W-1:0] a, input logic [7:0] d);
    busWrite(8'h40, a);
    busWrite(d, a);
  endtask

  task automatic tReset();
    logic [DATA_W-1:0] d;
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    for (int i = 0; i < DEPTH; i++) expMem[i] = DATA_W'(i * 29 + 7);
    chk("R1 status", statusOut, 8'h80);
    chk("R1 rdyBusy", rdyBusy, 1);
    chk("R1 readArray", readArray, 1);
    chk("R1 pauseReq", pauseReq, 0);
    readAt(3, d);
    chk("R1 init word", d, expMem[3]);
  endtask

  task automatic tIdleCmds();
    logic [DATA_W-1:0] d;
    busWrite(8'h70, 0);
    chk("R10 status mode", readArray, 0);
    readAt(0, d);
    chk("R10 status read", d, 8'h80);
    busWrite(8'hB0, 0);
    chk("R10 idle pause pauseReq", pauseReq, 0);
    chk("R10 idle pause status", statusOut, 8'h80);
    chk("R10 idle pause mode kept", readArray, 0);
    busWrite(8'hFF, 0);
    busWrite(8'hB0, 0);
    chk("R10 array mode kept", readArray, 1);
    readAt(5, d);
    chk("R10 array read", d, expMem[5]);
  endtask

  task automatic tProgram();
    logic [DATA_W-1:0] d;
    startProgram(2, 8'h3C);
    chk("R2 status busy", statusOut, 8'h00);
    chk("R2 rdyBusy", rdyBusy, 0);
    chk("R2 status mode", readArray, 0);
    for (int i = 1; i < PROG_CYCLES; i++) begin
      @(negedge clk);
      chk("R2 still busy", rdyBusy, 0);
    end
    @(negedge clk);
    chk("R2 done ready", rdyBusy, 1);
    chk("R2 done status", statusOut, 8'h80);
    busWrite(8'hFF, 0);
    expMem[2] = 8'h3C;
    readAt(2, d);
    chk("R2 word written", d, 8'h3C);
  endtask

  task automatic tPauseResume();
    logic [DATA_W-1:0] d;
    startProgram(6, 8'hE1);
    busWrite(8'hB0, 0);
    chk("R3 pauseReq raised", pauseReq, 1);
    chk("R3 busy after pause cmd", rdyBusy, 0);
    for (int i = 1; i < SUSP_LAT; i++) begin
      @(negedge clk);
      chk("R3 busy during latency", rdyBusy, 0);
    end
    @(negedge clk);
    chk("R3 paused at latency", rdyBusy, 1);
    chk("R4 paused status", statusOut, 8'h84);
    readAt(6, d);
    chk("R5 reads return status", d, 8'h84);
    busWrite(8'h40, 6);
    chk("R8 bad cmd status", statusOut, 8'h84);
    chk("R8 bad cmd mode", readArray, 0);
    chk("R8 bad cmd pauseReq", pauseReq, 1);
    busWrite(8'hFF, 0);
    chk("R6 array mode", readArray, 1);
    readAt(9, d);
    chk("R6 other word", d, expMem[9]);
    readAt(6, d);
    chk("R7 target old data", d, expMem[6]);
    busWrite(8'h55, 6);
    chk("R8 bad cmd in array mode", readArray, 1);
    chk("R8 status kept", statusOut, 8'h84);
    busWrite(8'h70, 0);
    chk("R12 status mode", readArray, 0);
    chk("R12 still paused", statusOut, 8'h84);
    busWrite(8'hFF, 0);
    busWrite(8'hD0, 0);
    chk("R9 status cleared", statusOut, 8'h00);
    chk("R9 busy", rdyBusy, 0);
    chk("R9 status mode", readArray, 0);
    chk("R9 pauseReq low", pauseReq, 0);
    waitReady("R9 completes", 3 * PROG_CYCLES);
    chk("R9 final status", statusOut, 8'h80);
    busWrite(8'hFF, 0);
    expMem[6] = 8'hE1;
    readAt(6, d);
    chk("R9 word written", d, 8'hE1);
  endtask

  task automatic tLatePause();
    logic [DATA_W-1:0] d;
    startProgram(11, 8'h77);
    repeat (PROG_CYCLES - 3) @(negedge clk);
    busWrite(8'hB0, 0);
    chk("R11 pending pauseReq", pauseReq, 1);
    @(negedge clk);
    chk("R11 still busy", rdyBusy, 0);
    @(negedge clk);
    chk("R11 done wins ready", rdyBusy, 1);
    chk("R11 no pause bit", statusOut, 8'h80);
    chk("R11 pauseReq drops", pauseReq, 0);
    busWrite(8'hFF, 0);
    expMem[11] = 8'h77;
    readAt(11, d);
    chk("R11 word written", d, 8'h77);
  endtask

  initial begin
    @(negedge clk);
    tReset();
    tIdleCmds();
    tProgram();
    tPauseResume();
    tLatePause();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    nCmp++;
    nBad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

endmodule